// File: doc/BRIEF.md
# Delayed-Parity Checker with Held Error Flag

This block sits next to a registered command/address buffer. On every enabled clock edge it captures a data word and forms the parity of a configuration-dependent subset of its bits. A parity input arrives one or two enabled clocks after the data it covers. The block folds that input into the stored data parity and presents the result as a partial-parity output. It also drives an active-low error flag. The flag goes low whenever the combined parity is odd and then stays low for a minimum number of enabled clocks.

Two configuration pins let one design serve three roles: a stand-alone checker, the first device of a pair, and the second device of a pair. In the pair roles, the first device's partial-parity output drives the second device's parity input. The second device therefore looks two clocks back. Two active-low select pins freeze the whole unit while both are high. There is no stream handshake: data is taken on every enabled edge, and no back-pressure path exists.

Top module: `dly_parity_chk`

## Requirements
- R1: While `rst_n` is low (asynchronous), `ppo` is 0 and `err_n` is 1.
- R2: On an enabled edge, `ppo` loads the parity of the selected bits of the data captured one enabled edge earlier (`cfg_upper`=0) or two enabled edges earlier (`cfg_upper`=1), XORed with `par_in` sampled at that edge.
- R3: Stand-alone mode (`cfg_dual`=0, `cfg_upper`=0): odd data captured at edge n with `par_in`=0 makes `err_n` low after edge n+2.
- R4: First-of-pair mode (`cfg_dual`=1, `cfg_upper`=0): odd data captured at edge n makes `err_n` low after edge n+1.
- R5: Second-of-pair mode (`cfg_dual`=1, `cfg_upper`=1): odd data captured at edge n with `par_in`=0 makes `err_n` low after edge n+2.
- R6: Once low, `err_n` stays low for at least HOLD_CYC (default 2) enabled edges. It returns high on the next enabled edge that finds no new error.
- R7: An error detected while the flag is already low restarts the hold, so the low time extends from the latest error.
- R8: An edge with both `cs_cmd_n` and `cs_rank_n` high changes no state: `ppo`, `err_n`, the hold timer and the captured data all keep their values, whatever `data_in` and `par_in` carry.
- R9: Bit `data_in[k-1]` is data line k. The selected lines are: stand-alone {2,3,5,6,8..25}; first-of-pair {2,3,5,6,8..14}; second-of-pair {1..6,8,9,10,12,13}. Other lines have no effect on `ppo` or `err_n`.
- R10: When `par_in` always equals the parity of the selected bits of the word it covers, `err_n` stays high and `ppo` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 0: stand-alone, 1: one device of a pair |
| cfg_upper | input | 1 | 0: parity input one clock late, 1: two clocks late |
| cs_cmd_n | input | 1 | Active-low select; with `cs_rank_n` high it freezes the unit |
| cs_rank_n | input | 1 | Active-low select; with `cs_cmd_n` high it freezes the unit |
| data_in | input | NBITS | Data word, line k on bit k-1 |
| par_in | input | 1 | Late parity input |
| ppo | output | 1 | Partial parity output |
| err_n | output | 1 | Active-low held error flag |

## Verification
The bench builds the block at its defaults, NBITS=25 and HOLD_CYC=2. This width reaches the highest stand-alone line, 25. It also contains the lines that are unselected in every mode (7) and those unselected in only some modes (11, 15). With a hold of two, a restart caused by a second error lands inside the hold window. A freeze can also fall between the error and its release, so the extension of the low time by frozen edges is observable.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // {cfg_dual, cfg_upper}
  typedef enum logic [1:0] {
    CFG_SINGLE  = 2'b00,
    CFG_RSVD    = 2'b01,
    CFG_PAIR_LO = 2'b10,
    CFG_PAIR_HI = 2'b11
  } cfg_e;

  function automatic cfg_e cfg_decode(input logic dual, input logic upper);
    return cfg_e'({dual, upper});
  endfunction

  // line numbers are 1-based: data line k sits on bit k-1
  function automatic logic line_selected(input cfg_e c, input int k);
    logic low_group;
    low_group = (k == 2) || (k == 3) || (k == 5) || (k == 6);
    case (c)
      CFG_PAIR_HI: return ((k >= 1) && (k <= 6)) || (k == 8) || (k == 9) ||
                          (k == 10) || (k == 12) || (k == 13);
      CFG_PAIR_LO: return low_group || ((k >= 8) && (k <= 14));
      default:     return low_group || (k >= 8);
    endcase
  endfunction

  // parity input two clocks late in these configurations
  function automatic logic late_align(input cfg_e c);
    return (c == CFG_PAIR_HI) || (c == CFG_RSVD);
  endfunction

endpackage

// File: rtl/dpc_mask_xor.sv
module dpc_mask_xor
  import dpc_pkg::*;
#(
  parameter int NBITS = 25
) (
  input  cfg_e             cfg,
  input  logic [NBITS-1:0] din,
  output logic             odd
);
  logic [NBITS-1:0] term;

  for (genvar g = 0; g < NBITS; g++) begin : g_term
    assign term[g] = din[g] & line_selected(cfg, g + 1);
  end

  assign odd = ^term;
endmodule

// File: rtl/dpc_align.sv
module dpc_align
  import dpc_pkg::*;
#(
  parameter int NBITS = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cfg_e             cfg,
  input  logic [NBITS-1:0] din,
  input  logic             par_in,
  output logic             p_now,
  output logic             ppo
);
  logic [NBITS-1:0] data_q;
  logic             late_q;
  logic             odd_now;
  logic             aligned;

  dpc_mask_xor #(.NBITS(NBITS)) u_xor (
    .cfg (cfg),
    .din (data_q),
    .odd (odd_now)
  );

  // one-late: parity of word from previous edge; two-late: one more stage
  assign aligned = late_align(cfg) ? late_q : odd_now;
  assign p_now   = aligned ^ par_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      late_q <= 1'b0;
      ppo    <= 1'b0;
    end else if (en) begin
      data_q <= din;
      late_q <= odd_now;
      ppo    <= p_now;
    end
  end
endmodule

// File: rtl/dpc_err_hold.sv
module dpc_err_hold #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic det,
  output logic err_n
);
  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n  <= 1'b1;
      left_q <= '0;
    end else if (en) begin
      if (det) begin
        err_n  <= 1'b0;
        left_q <= RELOAD;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end else begin
        err_n <= 1'b1;
      end
    end
  end

  // R6: a release is preceded by at least two low samples
  p_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> !$past(err_n, 2));
endmodule

// File: rtl/dly_parity_chk.sv
module dly_parity_chk
  import dpc_pkg::*;
#(
  parameter int NBITS    = 25,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             cfg_upper,
  input  logic             cs_cmd_n,
  input  logic             cs_rank_n,
  input  logic [NBITS-1:0] data_in,
  input  logic             par_in,
  output logic             ppo,
  output logic             err_n
);
  cfg_e cfg;
  logic en;
  logic p_now;
  logic det;

  assign cfg = cfg_decode(cfg_dual, cfg_upper);
  assign en  = !(cs_cmd_n && cs_rank_n);

  dpc_align #(.NBITS(NBITS)) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .cfg    (cfg),
    .din    (data_in),
    .par_in (par_in),
    .p_now  (p_now),
    .ppo    (ppo)
  );

  // pair devices flag at the aligning edge; stand-alone waits one more stage
  assign det = cfg_dual ? p_now : ppo;

  dpc_err_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .det   (det),
    .err_n (err_n)
  );

  a_rst_r1: assert property (@(posedge clk)
    !rst_n |-> (err_n && !ppo));

  p_single_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_dual && ppo) |=> !err_n);

  p_pair_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_dual && p_now) |=> !err_n);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(ppo) && $stable(err_n)));
endmodule

// File: tb/sim_dly_parity_chk.sv
`timescale 1ns/1ps
module sim_dly_parity_chk;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        c1 = 1'b0, c0 = 1'b0;
  logic        csa = 1'b1, csb = 1'b0;
  logic [24:0] data = '0;
  logic        par = 1'b0;
  logic        ppo, err_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dly_parity_chk #(.NBITS(25), .HOLD_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dual(c1), .cfg_upper(c0),
    .cs_cmd_n(csa), .cs_rank_n(csb), .data_in(data), .par_in(par),
    .ppo(ppo), .err_n(err_n)
  );

  function automatic bit sel_line(bit d, bit u, int k);
    bit lo;
    lo = (k == 2) || (k == 3) || (k == 5) || (k == 6);
    if (d && u) return (k <= 6) || (k == 8) || (k == 9) || (k == 10) || (k == 12) || (k == 13);
    if (d) return lo || (k >= 8 && k <= 14);
    return lo || (k >= 8);
  endfunction

  function automatic bit wpar(bit d, bit u, logic [24:0] w);
    bit p = 0;
    for (int k = 1; k <= 25; k++) if (sel_line(d, u, k)) p ^= w[k-1];
    return p;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: per enabled edge, history of word parities
  bit hist[$];
  bit m_ppo = 0, m_err = 1;
  int m_e = 0, m_last = -100;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_ppo = 0; m_err = 1; m_e = 0; m_last = -100;
    end else if (!(csa && csb)) begin
      bit old, pn, det;
      int lag;
      m_e++;
      lag = c0 ? 1 : 0;
      old = (hist.size() > lag) ? hist[lag] : 1'b0;
      pn  = old ^ par;
      det = c1 ? pn : m_ppo;
      m_ppo = pn;
      if (det) m_last = m_e;
      m_err = !((m_e - m_last) < 2);
      hist.push_front(wpar(c1, c0, data));
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (rst_n !== 1'bx) begin
    chk("R2 ppo vs model", ppo, rst_n ? m_ppo : 1'b0);
    chk("R6 err_n vs model", err_n, rst_n ? m_err : 1'b1);
  end

  task automatic drive(input logic [24:0] d, input logic p, input logic a, input logic b);
    @(posedge clk); #1;
    data = d; par = p; csa = a; csb = b;
  endtask

  task automatic do_reset(input logic d, input logic u);
    @(posedge clk); #1;
    rst_n = 0; c1 = d; c0 = u; data = '0; par = 0; csa = 1; csb = 0;
    @(negedge clk);
    chk("R1 reset ppo", ppo, 1'b0);
    chk("R1 reset err_n", err_n, 1'b1);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) drive('0, 0, 1, 0);
  endtask

  // single line k driven for one edge n; err low after n+lat..n+lat+1
  task automatic lat_case(input string tag, input logic d, input logic u, input int k,
                          input int lat, input bit active);
    do_reset(d, u);
    drive(25'(1) << (k - 1), 0, 1, 0);
    drive('0, 0, 1, 0);
    for (int j = 0; j <= 4; j++) begin
      @(negedge clk);
      chk({tag, " err_n"}, err_n, !(active && j >= lat && j <= lat + 1));
      chk({tag, " ppo"}, ppo, active && (j == (u ? 2 : 1)));
    end
  endtask

  task automatic clean_run(input string tag, input logic d, input logic u);
    bit h1 = 0, h2 = 0;
    do_reset(d, u);
    for (int i = 0; i < 40; i++) begin
      logic [24:0] w;
      bit p;
      w = 25'($urandom);
      p = u ? h2 : h1;
      drive(w, p, 1, 0);
      h2 = h1; h1 = wpar(d, u, w);
      @(negedge clk);
      chk({tag, " err_n"}, err_n, 1'b1);
      chk({tag, " ppo"}, ppo, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R3, R4, R5: latency per configuration; R9: unselected lines
    lat_case("R3 single D2", 0, 0, 2, 2, 1);
    lat_case("R3 single D25", 0, 0, 25, 2, 1);
    lat_case("R4 pairA D14", 1, 0, 14, 1, 1);
    lat_case("R5 pairB D1", 1, 1, 1, 2, 1);
    lat_case("R5 pairB D13", 1, 1, 13, 2, 1);
    lat_case("R9 single D7", 0, 0, 7, 2, 0);
    lat_case("R9 pairA D15", 1, 0, 15, 1, 0);
    lat_case("R9 pairB D11", 1, 1, 11, 2, 0);
    lat_case("R9 pairB D7", 1, 1, 7, 2, 0);

    // R7: second error at edge n+2 extends the low time
    do_reset(1, 0);
    drive(25'h2, 0, 1, 0);
    drive('0, 0, 1, 0);
    drive(25'h2, 0, 1, 0);
    drive('0, 0, 1, 0);
    for (int j = 2; j <= 6; j++) begin
      @(negedge clk);
      chk("R7 restart err_n", err_n, !(j <= 4));
    end

    // R8: four frozen edges with junk inputs between error and release
    do_reset(1, 0);
    drive(25'h2, 0, 1, 0);
    drive('0, 0, 1, 0);
    for (int i = 0; i < 4; i++) drive(25'h1ffffff, 1, 1, 1);
    drive('0, 0, 1, 0);
    @(negedge clk);
    chk("R8 frozen ppo kept", ppo, 1'b1);
    chk("R8 frozen err_n kept", err_n, 1'b0);
    @(negedge clk);
    chk("R8 err_n after unfreeze", err_n, 1'b0);
    @(negedge clk);
    chk("R6 err_n released", err_n, 1'b1);
    chk("R8 ppo follows stored word", ppo, 1'b0);

    // R10: matching parity input never flags
    clean_run("R10 single", 0, 0);
    clean_run("R10 pairA", 1, 0);
    clean_run("R10 pairB", 1, 1);

    // random traffic, model compare every clock (R2, R6, R8)
    for (int m = 0; m < 3; m++) begin
      do_reset(m != 0, m == 2);
      for (int i = 0; i < 400; i++) begin
        bit fz;
        fz = ($urandom % 4) == 0;
        drive(25'($urandom), 1'($urandom % 3 == 0), fz ? 1'b1 : 1'($urandom),
              fz ? 1'b1 : 1'b0);
      end
    end
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule